// File: doc/BRIEF.md
# Affector-Masked History Index Hasher

This block turns a long record of recent conditional-branch outcomes into a short index for a prediction table. Alongside the outcome history it receives a same-length bitmap marking which past branches actually influence the branch being predicted. History bits that the bitmap does not mark are discarded before the index is formed. The aim is that unrelated branches in a long history do not dilute the index.

Two ways of discarding are offered, picked per lookup by a mode input. In zeroing mode the unmarked bits are forced to 0 and the marked bits keep their positions. In packing mode the unmarked positions are removed, and the marked bits slide down toward bit 0 in their original relative order. In both modes the resulting H-bit vector is cut into N-bit slices starting at the LSB. The top slice is zero-padded, and all slices are XORed together to give the N-bit index. The datapath is combinational, and by default it ends in an output register with synchronous active-high reset.

Top module: `ahx_index_hash`

## Requirements
- R1: While `rst` is high at a rising clock edge, `idx_o` is 0 after that edge.
- R2: With `mode_i` = 0 (zeroing), `idx_o` equals the fold of `hist_i & affm_i`. Each surviving bit keeps its original position, so history bit k lands on index bit k mod N.
- R3: With `mode_i` = 1 (packing), the marked history bits are compacted with their relative order kept. The lowest-positioned marked bit becomes packed bit 0, the next becomes packed bit 1, and so on.
- R4: In packing mode, every packed bit at position at or above the number of ones in `affm_i` is 0.
- R5: The fold splits the H-bit vector into ceil(H/N) slices, with slice c covering bits c*N to c*N+N-1. Bits above H-1 in the last slice are 0, and all slices are XORed. With H=64 and N=12, history bit 63 in zeroing mode drives index bit 3.
- R6: History bits whose bitmap bit is 0 have no effect on `idx_o` in either mode.
- R7: An all-zero `affm_i` gives `idx_o` = 0 in both modes.
- R8: With an all-ones `affm_i`, both modes give the same index.
- R9: With the default OUT_REG=1, `idx_o` reflects the inputs present at the previous rising edge. It holds its value while those inputs are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = zeroing, 1 = packing |
| hist_i | input | H | Global branch outcome history, bit 0 most recent |
| affm_i | input | H | Affector bitmap, 1 marks a correlated history bit |
| idx_o | output | N | Hashed table index |

## Verification
The bench aims at the packing order, using a sparse bitmap whose high bit is set and whose low bit is clear. A design that packed from the top, or reversed the order, would put the set bit on the wrong index bit. It places a lone marked bit at position 63 to probe the zero-padded top slice; a fold that wrapped or dropped the partial slice gives 0 or a wrong bit instead of 0x008. It flips only unmarked history bits and expects an unchanged index; leaking masking logic would change it. It also checks empty and full bitmaps, where the two modes must agree.

// File: rtl/ahx_pkg.sv
package ahx_pkg;
  typedef enum logic {
    AHX_ZERO = 1'b0,
    AHX_PACK = 1'b1
  } ahx_mode_e;

  localparam int AHX_DEF_HIST = 64;
  localparam int AHX_DEF_IDX  = 12;
endpackage

// File: rtl/ahx_mask.sv
module ahx_mask #(
  parameter int H = ahx_pkg::AHX_DEF_HIST
) (
  input  logic [H-1:0] hist_i,
  input  logic [H-1:0] affm_i,
  output logic [H-1:0] kept_o
);
  // each history bit survives only where its bitmap bit is set
  for (genvar b = 0; b < H; b++) begin : g_bit
    assign kept_o[b] = hist_i[b] & affm_i[b];
  end
endmodule

// File: rtl/ahx_packer.sv
module ahx_packer #(
  parameter int H = ahx_pkg::AHX_DEF_HIST
) (
  input  logic [H-1:0] kept_i,
  input  logic [H-1:0] affm_i,
  output logic [H-1:0] packed_o
);
  localparam int CW = $clog2(H + 1);

  // running count of marked positions below each bit gives its packed slot
  logic [CW-1:0] slot [H+1];

  always_comb begin
    slot[0] = '0;
    for (int i = 0; i < H; i++) begin
      slot[i+1] = slot[i] + CW'(affm_i[i]);
    end
  end

  always_comb begin
    packed_o = '0;
    for (int i = 0; i < H; i++) begin
      if (affm_i[i]) begin
        packed_o[slot[i]] = kept_i[i];
      end
    end
  end
endmodule

// File: rtl/ahx_fold.sv
module ahx_fold #(
  parameter int H = ahx_pkg::AHX_DEF_HIST,
  parameter int N = ahx_pkg::AHX_DEF_IDX
) (
  input  logic [H-1:0] vec_i,
  output logic [N-1:0] fold_o
);
  localparam int SLICES = (H + N - 1) / N;
  localparam int PADW   = SLICES * N;

  logic [PADW-1:0] padded;
  logic [N-1:0]    part [SLICES];

  always_comb begin
    padded        = '0;
    padded[H-1:0] = vec_i;
  end

  for (genvar c = 0; c < SLICES; c++) begin : g_slice
    if (c == 0) begin : g_first
      assign part[c] = padded[N-1:0];
    end else begin : g_next
      assign part[c] = part[c-1] ^ padded[c*N +: N];
    end
  end

  assign fold_o = part[SLICES-1];
endmodule

// File: rtl/ahx_index_hash.sv
module ahx_index_hash #(
  parameter int H       = ahx_pkg::AHX_DEF_HIST,
  parameter int N       = ahx_pkg::AHX_DEF_IDX,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_i,
  input  logic [H-1:0] hist_i,
  input  logic [H-1:0] affm_i,
  output logic [N-1:0] idx_o
);
  import ahx_pkg::*;

  logic [H-1:0] zeroed_w;
  logic [H-1:0] packed_w;
  logic [H-1:0] chosen_w;
  logic [N-1:0] fold_w;
  ahx_mode_e    mode_w;

  assign mode_w = ahx_mode_e'(mode_i);

  ahx_mask #(.H(H)) u_mask (
    .hist_i (hist_i),
    .affm_i (affm_i),
    .kept_o (zeroed_w)
  );

  ahx_packer #(.H(H)) u_pack (
    .kept_i   (zeroed_w),
    .affm_i   (affm_i),
    .packed_o (packed_w)
  );

  assign chosen_w = (mode_w == AHX_PACK) ? packed_w : zeroed_w;

  ahx_fold #(.H(H), .N(N)) u_fold (
    .vec_i  (chosen_w),
    .fold_o (fold_w)
  );

  if (OUT_REG) begin : g_reg
    logic [N-1:0] idx_q;
    always_ff @(posedge clk) begin
      if (rst) idx_q <= '0;
      else     idx_q <= fold_w;
    end
    assign idx_o = idx_q;
  end else begin : g_comb
    assign idx_o = fold_w;
  end
endmodule

// File: rtl/ahx_index_hash_chk.sv
module ahx_index_hash_chk #(
  parameter int H       = 64,
  parameter int N       = 12,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_i,
  input logic [H-1:0] hist_i,
  input logic [H-1:0] affm_i,
  input logic [H-1:0] zeroed_w,
  input logic [H-1:0] packed_w,
  input logic [N-1:0] idx_o
);
  // R6
  masked_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (zeroed_w & ~affm_i) == '0);

  // R3
  pack_keeps_ones_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(packed_w) == $countones(hist_i & affm_i));

  // R4
  pack_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (packed_w >> $countones(affm_i)) == '0);

  // R8
  full_map_same_chk: assert property (@(posedge clk) disable iff (rst)
    (affm_i == '1) |-> (packed_w == zeroed_w));

  if (OUT_REG) begin : g_seq
    // R1
    reset_idx_zero_chk: assert property (@(posedge clk)
      rst |=> (idx_o == '0));

    // R7
    empty_map_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (affm_i == '0) |=> (idx_o == '0));

    // R9
    held_inputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(hist_i) && $stable(affm_i) && $stable(mode_i) && !$past(rst))
      |=> $stable(idx_o));
  end
endmodule

bind ahx_index_hash ahx_index_hash_chk #(.H(H), .N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_i   (mode_i),
  .hist_i   (hist_i),
  .affm_i   (affm_i),
  .zeroed_w (zeroed_w),
  .packed_w (packed_w),
  .idx_o    (idx_o)
);

// File: tb/ahx_index_hash_tb.sv
module ahx_index_hash_tb;
  localparam int H = 64;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_i = 1'b0;
  logic [H-1:0] hist_i = '0;
  logic [H-1:0] affm_i = '0;
  logic [N-1:0] idx_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  ahx_index_hash #(.H(H), .N(N), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .hist_i(hist_i), .affm_i(affm_i), .idx_o(idx_o)
  );

  always #5 clk = ~clk;

  function automatic logic [N-1:0] ref_fold(input logic [H-1:0] v);
    logic [N-1:0] acc = '0;
    for (int b = 0; b < H; b++) acc[b % N] ^= v[b];
    return acc;
  endfunction

  function automatic logic [N-1:0] ref_idx(input logic [H-1:0] h,
                                           input logic [H-1:0] m,
                                           input logic md);
    logic [H-1:0] v = '0;
    int k = 0;
    for (int b = 0; b < H; b++) begin
      if (m[b]) begin
        if (md) begin v[k] = h[b]; k++; end
        else v[b] = h[b];
      end
    end
    return ref_fold(v);
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    checks++;
    if (idx_o !== exp) begin
      errors++;
      $display("FAIL %s: idx=%h expected=%h", req, idx_o, exp);
    end
  endtask

  task automatic step(input logic [H-1:0] h, input logic [H-1:0] m, input logic md);
    @(negedge clk);
    hist_i = h; affm_i = m; mode_i = md;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    hist_i = '1; affm_i = '1; mode_i = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    check("R1", '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_zero_mode();
    for (int i = 0; i < 8; i++) begin
      logic [H-1:0] h, m;
      seed = nxt(seed); h = seed;
      seed = nxt(seed); m = seed;
      step(h, m, 1'b0);
      check("R2", ref_idx(h, m, 1'b0));
    end
  endtask

  task automatic t_pack_mode();
    for (int i = 0; i < 8; i++) begin
      logic [H-1:0] h, m;
      seed = nxt(seed); h = seed;
      seed = nxt(seed); m = seed;
      step(h, m, 1'b1);
      check("R3", ref_idx(h, m, 1'b1));
    end
  endtask

  task automatic t_order();
    logic [H-1:0] h = '0, m = '0;
    m[5] = 1'b1; m[40] = 1'b1; h[40] = 1'b1;
    step(h, m, 1'b1);
    check("R3 order", 12'h002);
    step(h, m, 1'b0);
    check("R2 position", 12'h010);
  endtask

  task automatic t_upper_zero();
    step('1, 64'hF0F0_0000_0000_0F0F, 1'b1);
    check("R4", 12'hFF0);
  endtask

  task automatic t_fold_pad();
    logic [H-1:0] h = '0, m = '0;
    h[63] = 1'b1; m[63] = 1'b1;
    step(h, m, 1'b0);
    check("R5 pad", 12'h008);
    step(h, m, 1'b1);
    check("R5 pack", 12'h001);
  endtask

  task automatic t_ignore();
    logic [H-1:0] m = 64'h0123_4567_89AB_CDEF;
    logic [H-1:0] h = 64'hDEAD_BEEF_CAFE_F00D;
    for (int md = 0; md < 2; md++) begin
      step(h, m, md[0]);
      check("R6 base", ref_idx(h, m, md[0]));
      step(h ^ ~m, m, md[0]);
      check("R6 flipped", ref_idx(h, m, md[0]));
    end
  endtask

  task automatic t_empty_map();
    step('1, '0, 1'b0);
    check("R7 zero", '0);
    step(64'hA5A5_5A5A_F00F_0FF0, '0, 1'b1);
    check("R7 pack", '0);
  endtask

  task automatic t_full_map();
    logic [H-1:0] h = 64'h1357_9BDF_2468_ACE0;
    step(h, '1, 1'b0);
    check("R8 zero", ref_fold(h));
    step(h, '1, 1'b1);
    check("R8 pack", ref_fold(h));
  endtask

  task automatic t_latency();
    logic [H-1:0] ha = 64'h0000_0000_0000_0ABC;
    logic [H-1:0] hb = 64'h0000_0000_0000_0123;
    step(ha, '1, 1'b0);
    check("R9 load", 12'hABC);
    @(posedge clk); #1;
    check("R9 hold", 12'hABC);
    @(negedge clk);
    hist_i = hb;
    #1;
    check("R9 before edge", 12'hABC);
    @(posedge clk); #1;
    check("R9 after edge", 12'h123);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_zero_mode();
    t_pack_mode();
    t_order();
    t_upper_zero();
    t_fold_pad();
    t_ignore();
    t_empty_map();
    t_full_map();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule